// File: doc/BRIEF.md
# Test Capacitor Selection and Annunciator Controller

This block is the front-panel logic of an in-circuit capacitor tester. Three raw push-button lines, a rocker's up arm, its down arm and a Set button, drive a cursor over eight internal test capacitors. The block also builds an active selection mask from them and keeps a stored default mask. Each button is synchronised and debounced, and each press is classified as short or long against a hold threshold. A short and a long press on the same button do different things.

The connection sequencer reports three flags: a connect phase, a disconnect phase and a fault. While any of them is high, every selection input is locked out. The block asks the sound generator for a tone when each phase begins, but only if the sounder is enabled. A rising fault always asks for an alert tone, and the display-invert output follows the fault. The default mask is held in a register with its own power-on reset. It survives the ordinary reset, and the ordinary reset loads it into the active mask.

Top module: `capsel_ui`

## Requirements
- R1: A button level is accepted only after it has stayed unchanged for DEB_CYC consecutive synchronised cycles (default 8). A shorter glitch has no effect.
- R2: A short press of the up arm advances the highlight index by one, and index 7 wraps to 0.
- R3: A short press of the down arm moves the highlight index back by one, and index 0 wraps to 7.
- R4: A short press of Set inverts bit `hl_idx_o` of `sel_mask_o`, so several capacitors can be active at once.
- R5: `sel_mask_o` is never zero. A Set toggle that would clear its only set bit is refused.
- R6: A long press of Set copies `sel_mask_o` into `def_mask_o`. `por_n` resets `def_mask_o` to 8'h01. One cycle after `rst_n` is released, `sel_mask_o` takes the value of `def_mask_o`.
- R7: A press counts as long once it has been held for LONG_CYC debounced cycles (default 200). A long press performs no short action on release.
- R8: A long press of either rocker arm inverts `snd_en_o`. `snd_en_o` resets to 1.
- R9: While `conn_ph_i`, `disc_ph_i` or `fault_i` is high, button presses leave the highlight, the active mask, the default mask and the sounder enable unchanged.
- R10: `disp_inv_o` follows `fault_i` one cycle later. A rising `fault_i` gives a one-cycle `tone_alert_o` pulse whatever the state of `snd_en_o`.
- R11: A rising `conn_ph_i` gives a one-cycle `tone_conn_o` pulse, and a rising `disc_ph_i` gives a one-cycle `tone_disc_o` pulse. Each pulse is produced only when `snd_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the stored default |
| rst_n | input | 1 | Operational reset, active low, asynchronous |
| rk_up_i | input | 1 | Raw up arm of the rocker, high when pressed |
| rk_dn_i | input | 1 | Raw down arm of the rocker, high when pressed |
| set_i | input | 1 | Raw Set button, high when pressed |
| conn_ph_i | input | 1 | Connect phase in progress |
| disc_ph_i | input | 1 | Disconnect phase in progress |
| fault_i | input | 1 | Over-voltage or reverse-voltage fault present |
| hl_idx_o | output | 3 | Highlighted capacitor index |
| sel_mask_o | output | 8 | Active capacitor mask, bit n for capacitor n |
| def_mask_o | output | 8 | Stored default mask |
| snd_en_o | output | 1 | Sounder enabled |
| disp_inv_o | output | 1 | Invert the display |
| tone_conn_o | output | 1 | One-cycle request for the connection tone |
| tone_disc_o | output | 1 | One-cycle request for the disconnection tone |
| tone_alert_o | output | 1 | One-cycle request for the alert tone |

## Verification
Several properties are checked by assertions on every cycle:
- the active mask is never empty;
- the interlock keeps the mask, the highlight, the default and the sounder bit still;
- the display inversion lags the fault by one cycle;
- each tone pulse lasts one cycle, and phase tones appear only with the sounder on;
- a short release never follows a long detection;
- the reload after reset copies the default.

Other behaviours can only be shown by the bench's press scenarios:
- rejection of a glitch shorter than the debounce window;
- wrap of the highlight in both directions;
- combining several capacitors;
- refusal of the last toggle;
- a default that survives the ordinary reset but not power-on;
- a long press suppressing its short action.

// File: rtl/capsel_pkg.sv
package capsel_pkg;
    // Classified button event, each field a one-cycle pulse
    typedef struct packed {
        logic short_p;
        logic long_p;
    } press_t;
endpackage

// File: rtl/capsel_btn.sv
module capsel_btn
    import capsel_pkg::*;
#(
    parameter int DEB_CYC  = 8,
    parameter int LONG_CYC = 200
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   raw_i,
    output press_t ev_o
);
    localparam int DW = $clog2(DEB_CYC + 1);
    localparam int HW = $clog2(LONG_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [DW-1:0] dcnt;
        logic [HW-1:0] hold;
        logic          long_seen;
        logic          short_p;
        logic          long_p;
    } btn_t;

    btn_t q, d;

    always_comb begin
        d         = q;
        d.s1      = raw_i;
        d.s2      = q.s1;
        d.short_p = 1'b0;
        d.long_p  = 1'b0;
        // debounce: accept a new level after DEB_CYC steady cycles
        if (q.s2 != q.lvl) begin
            if (q.dcnt == DW'(DEB_CYC - 1)) begin
                d.lvl  = q.s2;
                d.dcnt = '0;
            end else begin
                d.dcnt = q.dcnt + 1'b1;
            end
        end else begin
            d.dcnt = '0;
        end
        // hold timer while pressed
        if (q.lvl) begin
            if (q.hold != HW'(LONG_CYC))
                d.hold = q.hold + 1'b1;
            if (q.hold == HW'(LONG_CYC - 1)) begin
                d.long_p    = 1'b1;
                d.long_seen = 1'b1;
            end
        end else begin
            d.hold = '0;
        end
        if (q.lvl && !d.lvl)
            d.short_p = !q.long_seen && !d.long_p;
        if (!q.lvl && d.lvl)
            d.long_seen = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ev_o.short_p = q.short_p;
    assign ev_o.long_p  = q.long_p;

    // R7: a release after a long detection is never reported as short
    a_r7_no_short_after_long: assert property (@(posedge clk) disable iff (!rst_n)
        q.short_p |-> !q.long_seen);
    // R1: the accepted level only changes to a value the synchroniser held
    a_r1_level_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lvl != $past(q.lvl)) |-> (q.lvl == $past(q.s2)));
endmodule

// File: rtl/capsel_ui.sv
module capsel_ui
    import capsel_pkg::*;
#(
    parameter int NCAP     = 8,
    parameter int DEB_CYC  = 8,
    parameter int LONG_CYC = 200
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     rst_n,
    input  logic                     rk_up_i,
    input  logic                     rk_dn_i,
    input  logic                     set_i,
    input  logic                     conn_ph_i,
    input  logic                     disc_ph_i,
    input  logic                     fault_i,
    output logic [$clog2(NCAP)-1:0]  hl_idx_o,
    output logic [NCAP-1:0]          sel_mask_o,
    output logic [NCAP-1:0]          def_mask_o,
    output logic                     snd_en_o,
    output logic                     disp_inv_o,
    output logic                     tone_conn_o,
    output logic                     tone_disc_o,
    output logic                     tone_alert_o
);
    localparam int              IDXW    = $clog2(NCAP);
    localparam int              NBTN    = 3;
    localparam logic [NCAP-1:0] DEF_RST = NCAP'(1);
    localparam logic [NCAP-1:0] ONE     = NCAP'(1);

    press_t         ev [NBTN];
    logic [NBTN-1:0] raw;
    assign raw = {set_i, rk_dn_i, rk_up_i};

    for (genvar g = 0; g < NBTN; g++) begin : g_btn
        capsel_btn #(.DEB_CYC(DEB_CYC), .LONG_CYC(LONG_CYC)) u_btn (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw[g]),
            .ev_o  (ev[g])
        );
    end

    typedef struct packed {
        logic [IDXW-1:0] hl;
        logic [NCAP-1:0] sel;
        logic            snd;
        logic            load;
        logic            conn_prev;
        logic            disc_prev;
        logic            fault_prev;
        logic            inv;
        logic            t_conn;
        logic            t_disc;
        logic            t_alert;
    } ui_t;

    ui_t             q, d;
    logic [NCAP-1:0] def_q, def_d;
    logic [NCAP-1:0] flip;
    logic            lock;

    assign lock = conn_ph_i | disc_ph_i | fault_i;

    always_comb begin
        d            = q;
        def_d        = def_q;
        flip         = q.sel ^ (ONE << q.hl);
        d.load       = 1'b0;
        d.conn_prev  = conn_ph_i;
        d.disc_prev  = disc_ph_i;
        d.fault_prev = fault_i;
        d.inv        = fault_i;
        d.t_conn     = conn_ph_i & ~q.conn_prev & q.snd;
        d.t_disc     = disc_ph_i & ~q.disc_prev & q.snd;
        d.t_alert    = fault_i & ~q.fault_prev;
        if (q.load) begin
            d.sel = def_q;
        end else if (!lock) begin
            if (ev[0].short_p)
                d.hl = (q.hl == IDXW'(NCAP - 1)) ? '0 : q.hl + 1'b1;
            else if (ev[1].short_p)
                d.hl = (q.hl == '0) ? IDXW'(NCAP - 1) : q.hl - 1'b1;
            if (ev[0].long_p || ev[1].long_p)
                d.snd = ~q.snd;
            if (ev[2].short_p && (flip != '0))
                d.sel = flip;
            if (ev[2].long_p)
                def_d = q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sel  <= DEF_RST;
            q.snd  <= 1'b1;
            q.load <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) def_q <= DEF_RST;
        else        def_q <= def_d;
    end

    assign hl_idx_o     = q.hl;
    assign sel_mask_o   = q.sel;
    assign def_mask_o   = def_q;
    assign snd_en_o     = q.snd;
    assign disp_inv_o   = q.inv;
    assign tone_conn_o  = q.t_conn;
    assign tone_disc_o  = q.t_disc;
    assign tone_alert_o = q.t_alert;

    a_r5_mask_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        sel_mask_o != '0);
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !q.load) |=> ($stable(sel_mask_o) && $stable(hl_idx_o)
                               && $stable(snd_en_o) && $stable(def_mask_o)));
    a_r6_reload_default: assert property (@(posedge clk) disable iff (!rst_n)
        q.load |=> (sel_mask_o == $past(def_mask_o)));
    a_r2_up_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && !q.load && ev[0].short_p && hl_idx_o == IDXW'(NCAP - 1))
        |=> (hl_idx_o == '0));
    a_r10_invert_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> disp_inv_o);
    a_r10_invert_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_i |=> !disp_inv_o);
    a_r10_alert_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_i) |=> tone_alert_o);
    a_r11_conn_needs_snd: assert property (@(posedge clk) disable iff (!rst_n)
        tone_conn_o |-> snd_en_o);
    a_r11_disc_needs_snd: assert property (@(posedge clk) disable iff (!rst_n)
        tone_disc_o |-> snd_en_o);
    a_r11_conn_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tone_conn_o |=> !tone_conn_o);
    a_r11_disc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tone_disc_o |=> !tone_disc_o);
endmodule

// File: tb/tb_capsel_ui.sv
module tb_capsel_ui;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       rk_up = 1'b0, rk_dn = 1'b0, set_b = 1'b0;
    logic       conn = 1'b0, disc = 1'b0, fault = 1'b0;
    logic [2:0] hl;
    logic [7:0] sel, defm;
    logic       snd, inv, t_conn, t_disc, t_alert;

    int total = 0, bad = 0;
    int n_conn = 0, n_disc = 0, n_alert = 0;
    bit done = 0;

    localparam int SHORT = 30;
    localparam int LONG  = 260;

    always #4 clk = ~clk;

    capsel_ui dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .rk_up_i(rk_up), .rk_dn_i(rk_dn), .set_i(set_b),
        .conn_ph_i(conn), .disc_ph_i(disc), .fault_i(fault),
        .hl_idx_o(hl), .sel_mask_o(sel), .def_mask_o(defm),
        .snd_en_o(snd), .disp_inv_o(inv),
        .tone_conn_o(t_conn), .tone_disc_o(t_disc), .tone_alert_o(t_alert)
    );

    always @(posedge clk) begin
        if (t_conn)  n_conn++;
        if (t_disc)  n_disc++;
        if (t_alert) n_alert++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // which: 0 up arm, 1 down arm, 2 Set
    task automatic press(input int which, input int hold);
        @(negedge clk);
        if (which == 0) rk_up = 1'b1;
        else if (which == 1) rk_dn = 1'b1;
        else set_b = 1'b1;
        idle(hold);
        rk_up = 1'b0; rk_dn = 1'b0; set_b = 1'b0;
        idle(40);
    endtask

    task automatic t_reset();
        chk("R6 por default", defm, 8'h01);
        chk("R6 reset selection", sel, 8'h01);
        chk("R2 reset highlight", hl, 0);
        chk("R8 reset sounder", snd, 1);
        chk("R10 reset invert", inv, 0);
    endtask

    task automatic t_glitch();
        @(negedge clk); set_b = 1'b1;
        idle(5);
        set_b = 1'b0;
        idle(40);
        chk("R1 glitch ignored", sel, 8'h01);
    endtask

    task automatic t_up();
        repeat (3) press(0, SHORT);
        chk("R2 up x3", hl, 3);
        repeat (4) press(0, SHORT);
        chk("R2 up to last", hl, 7);
        press(0, SHORT);
        chk("R2 wrap 7 to 0", hl, 0);
    endtask

    task automatic t_down();
        press(1, SHORT);
        chk("R3 wrap 0 to 7", hl, 7);
        press(1, SHORT);
        chk("R3 down", hl, 6);
        repeat (2) press(0, SHORT);
        chk("R2 back to 0", hl, 0);
    endtask

    task automatic t_toggle();
        press(0, SHORT); press(2, SHORT);
        chk("R4 add cap1", sel, 8'h03);
        press(0, SHORT); press(2, SHORT);
        chk("R4 add cap2", sel, 8'h07);
        press(2, SHORT);
        chk("R4 remove cap2", sel, 8'h03);
    endtask

    task automatic t_last();
        press(1, SHORT); press(1, SHORT);
        press(2, SHORT);
        chk("R4 remove cap0", sel, 8'h02);
        press(0, SHORT); press(2, SHORT);
        chk("R5 last bit kept", sel, 8'h02);
        press(1, SHORT); press(2, SHORT);
        chk("R4 re-add cap0", sel, 8'h03);
    endtask

    task automatic t_default();
        press(2, LONG);
        chk("R6 long set stores", defm, 8'h03);
        chk("R7 long set no toggle", sel, 8'h03);
        @(negedge clk); rst_n = 1'b0;
        idle(3); rst_n = 1'b1;
        idle(5);
        chk("R6 reload after reset", sel, 8'h03);
        chk("R6 default survives reset", defm, 8'h03);
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        idle(3); por_n = 1'b1; rst_n = 1'b1;
        idle(5);
        chk("R6 por clears default", defm, 8'h01);
        chk("R6 por reload", sel, 8'h01);
    endtask

    task automatic t_sound();
        press(0, LONG);
        chk("R8 long up mutes", snd, 0);
        chk("R7 long up no move", hl, 0);
        press(1, LONG);
        chk("R8 long down unmutes", snd, 1);
        chk("R7 long down no move", hl, 0);
    endtask

    task automatic t_lock();
        @(negedge clk); conn = 1'b1;
        press(0, SHORT); press(2, SHORT); press(2, LONG); press(0, LONG);
        chk("R9 conn hl", hl, 0);
        chk("R9 conn sel", sel, 8'h01);
        chk("R9 conn def", defm, 8'h01);
        chk("R9 conn snd", snd, 1);
        conn = 1'b0; disc = 1'b1;
        press(1, SHORT);
        chk("R9 disc hl", hl, 0);
        disc = 1'b0; fault = 1'b1;
        press(0, SHORT); press(2, SHORT);
        chk("R9 fault hl", hl, 0);
        chk("R9 fault sel", sel, 8'h01);
        fault = 1'b0;
        idle(5);
    endtask

    task automatic t_tones();
        int c0, d0, a0;
        c0 = n_conn; d0 = n_disc; a0 = n_alert;
        @(negedge clk); conn = 1'b1; idle(10); conn = 1'b0; idle(5);
        chk("R11 conn tone", n_conn - c0, 1);
        disc = 1'b1; idle(10); disc = 1'b0; idle(5);
        chk("R11 disc tone", n_disc - d0, 1);
        press(0, LONG);
        chk("R8 muted again", snd, 0);
        c0 = n_conn;
        conn = 1'b1; idle(10); conn = 1'b0; idle(5);
        chk("R11 no tone when muted", n_conn - c0, 0);
        fault = 1'b1; idle(3);
        chk("R10 invert on fault", inv, 1);
        chk("R10 alert while muted", n_alert - a0, 1);
        fault = 1'b0; idle(3);
        chk("R10 invert cleared", inv, 0);
    endtask

    initial begin
        idle(4);
        por_n = 1'b1; rst_n = 1'b1;
        idle(4);
        t_reset();
        t_glitch();
        t_up();
        t_down();
        t_toggle();
        t_last();
        t_default();
        t_sound();
        t_lock();
        t_tones();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule